// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Master

This block is a serial peripheral (SPI) master that software drives through a small bank of 32-bit registers on a simple write-strobe bus with combinational read data. Software programs clock polarity, clock phase, bit order, word length, a two-range clock prescaler, an internal loopback path and an alternate data-justification mode in the configuration register. It then writes a word into the transmit register. That write starts one full-duplex word transfer: the word goes out on the data-out pin while a word is captured from the data-in pin.

When the word is complete, the captured data is placed in the receive register. Two event flags then report "received word waiting" and "transmitter free". Software clears the flags by writing ones to them. A mask register selects which flags drive the single interrupt output. Chip selects are handled outside the block by general-purpose pins. There is no slave mode and no queueing beyond a single word.

Top module: `sermst_ctrl`

## Requirements
- R1: After reset the configuration, mask, command, transmit and receive registers read 0, the event register reads 0x0000_0100, `irq` is low and `sck` is low.
- R2: Registers sit at byte addresses 0x20 configuration, 0x24 event, 0x28 mask, 0x2C command, 0x30 transmit and 0x34 receive. Configuration bits are 30 loopback, 29 idle-high clock, 28 phase, 27 slow range, 26 MSB-first, 25 master, 24 enable, 23:20 length code, 19:16 prescale P and 14 alternate justification. Every other configuration bit reads 0. Mask bits 9:8 are stored and the rest read 0. The command register stores all 32 bits.
- R3: Length code c selects c+1 bits for c from 3 to 15 and 32 bits for c=0 (codes 1 and 2 act as 4 bits). Transmit bits above the word length are not sent, and receive bits above it read 0.
- R4: One `sck` period lasts 4·(P+1) clocks when the slow-range bit is 0 and 64·(P+1) clocks when it is 1, with equal high and low halves.
- R5: Between transfers `sck` rests at the idle-high bit. With phase 0, data is presented before the first clock edge and sampled on odd edges. With phase 1, data changes on odd edges and is sampled on even edges. Data-in is sampled in the same pattern.
- R6: With MSB-first set the most significant bit of the word travels first, and with it clear the least significant bit travels first. This holds in both directions.
- R7: A write to transmit while enabled and idle starts one word transfer. At its end the captured word is in the receive register, and event bit 9 (received) and bit 8 (free) are both set. Bit 8 reads 0 for the whole transfer. A transmit write while busy or disabled is ignored.
- R8: Writing a 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when some event bit is set and the mask bit at the same position is set.
- R10: With alternate justification and MSB-first, words of up to 8 bits are sent from transmit bits 31:24 and received into bits 23:16. Words of 9 to 16 bits use bit 16 for both. With alternate justification and LSB-first, words are sent from bit 0, and words of up to 8 bits are received starting at bit 8.
- R11: With loopback set the received word equals the sent word, and `miso` has no effect.
- R12: While enable is 1, a configuration write changes only the enable bit. Clearing enable aborts a transfer in progress, returns `sck` to idle at once, clears event bit 9, sets bit 8, and no completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Masked event interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench runs a behavioural slave that presents and captures bits on the opposite edges from the master. A design with the edge roles swapped, or with a bit order reversed, therefore hands back the slave's word bit-reversed or shifted by one. It measures the high time of `sck` in both prescaler ranges, which catches a missing +1 on P or the wrong range multiplier. Loopback is run with `miso` held at all ones, so a design that leaks the pin returns 0xFF instead of the sent word. Alternate justification is tested at the boundaries (8, 12 and LSB-first 8 bits), where a wrong shift lands data in the wrong byte. Finally, a slow transfer is aborted halfway. A design that let it finish, left `sck` high, or kept a stale received flag shows up in the event register.

// File: rtl/sermst_pkg.sv
// Shared constants, configuration type and helper functions for the serial master.
// Assumes a 32-bit register file with byte addressing.
package sermst_pkg;

    localparam int REG_W   = 32;
    localparam int PM_W    = 4;
    localparam int LEN_W   = 4;
    localparam int NB_W    = 6;                 // holds 1..32
    localparam int HALF_LO = 2;                 // half period per P step, fast range
    localparam int HALF_HI = 32;                // half period per P step, slow range
    localparam int CNT_W   = PM_W + $clog2(HALF_HI) + 1;

    localparam logic [7:0] OFS_CFG  = 8'h20;
    localparam logic [7:0] OFS_EVT  = 8'h24;
    localparam logic [7:0] OFS_MSK  = 8'h28;
    localparam logic [7:0] OFS_CMD  = 8'h2C;
    localparam logic [7:0] OFS_TXD  = 8'h30;
    localparam logic [7:0] OFS_RXD  = 8'h34;

    localparam int B_LOOP  = 30;
    localparam int B_CPOL  = 29;
    localparam int B_CPHA  = 28;
    localparam int B_SLOW  = 27;
    localparam int B_MSBF  = 26;
    localparam int B_MSTR  = 25;
    localparam int B_EN    = 24;
    localparam int B_LEN   = 20;
    localparam int B_PM    = 16;
    localparam int B_ALT   = 14;
    localparam int E_RXW   = 9;
    localparam int E_TXF   = 8;

    localparam logic [REG_W-1:0] CFG_KEEP = 32'h7FFF_4000;

    typedef struct packed {
        logic            loop;
        logic            cpol;
        logic            cpha;
        logic            slow;
        logic            msbf;
        logic            alt;
        logic [NB_W-1:0] nbits;
        logic [PM_W-1:0] pm;
    } cfg_t;

    // Length code to bit count: 0 means 32, codes below 3 are raised to 4 bits.
    function automatic logic [NB_W-1:0] code_to_bits(input logic [LEN_W-1:0] c);
        if (c == '0)
            return NB_W'(32);
        else if (c < LEN_W'(3))
            return NB_W'(4);
        else
            return NB_W'(c) + NB_W'(1);
    endfunction

    // Unpack the stored configuration word into named fields.
    function automatic cfg_t unpack_cfg(input logic [REG_W-1:0] m);
        cfg_t c;
        c.loop  = m[B_LOOP];
        c.cpol  = m[B_CPOL];
        c.cpha  = m[B_CPHA];
        c.slow  = m[B_SLOW];
        c.msbf  = m[B_MSBF];
        c.alt   = m[B_ALT];
        c.nbits = code_to_bits(m[B_LEN +: LEN_W]);
        c.pm    = m[B_PM +: PM_W];
        return c;
    endfunction

    // Mask keeping only the low n bits of a register word.
    function automatic logic [REG_W-1:0] len_mask(input logic [NB_W-1:0] n);
        if (n >= NB_W'(REG_W))
            return '1;
        else
            return (REG_W'(1) << n) - REG_W'(1);
    endfunction

endpackage

// File: rtl/sermst_prescale.sv
// Serial clock prescaler: emits a one-cycle tick at every half period of sck.
// Assumes the run input stays high for the whole transfer; the counter
// reloads while idle so the first tick comes one full half period after start.
module sermst_prescale
    import sermst_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            slow,
    input  logic [PM_W-1:0] pm,
    output logic            tick
);

    localparam int SH_LO = $clog2(HALF_LO);
    localparam int SH_HI = $clog2(HALF_HI);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] reload;

    // Half period minus one, taken from the range bit and the P field.
    always_comb begin
        step   = CNT_W'(pm) + CNT_W'(1);
        reload = (slow ? (step << SH_HI) : (step << SH_LO)) - CNT_W'(1);
    end

    assign tick = run && (cnt_q == '0);

    // Down counter that reloads at each tick and while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || cnt_q == '0)
            cnt_q <= reload;
        else
            cnt_q <= cnt_q - CNT_W'(1);
    end

endmodule

// File: rtl/sermst_align.sv
// Data justification between the 32-bit registers and the right-justified
// shift word. Normal mode uses bit 0 in both directions. Alternate mode
// moves data up according to bit order and word length.
module sermst_align
    import sermst_pkg::*;
(
    input  cfg_t             cfg,
    input  logic [REG_W-1:0] tx_reg,
    input  logic [REG_W-1:0] rx_word,
    output logic [REG_W-1:0] tx_word,
    output logic [REG_W-1:0] rx_view
);

    logic [4:0]       tx_sh;
    logic [4:0]       rx_sh;
    logic [REG_W-1:0] keep;

    // Pick the shift distances for each direction.
    always_comb begin
        tx_sh = 5'd0;
        rx_sh = 5'd0;
        if (cfg.alt) begin
            if (cfg.msbf) begin
                if (cfg.nbits <= NB_W'(8)) begin
                    tx_sh = 5'd24;
                    rx_sh = 5'd16;
                end else if (cfg.nbits <= NB_W'(16)) begin
                    tx_sh = 5'd16;
                    rx_sh = 5'd16;
                end
            end else if (cfg.nbits <= NB_W'(8)) begin
                rx_sh = 5'd8;
            end
        end
    end

    // Apply shifts and trim to the word length.
    always_comb begin
        keep    = len_mask(cfg.nbits);
        tx_word = (tx_reg >> tx_sh) & keep;
        rx_view = (rx_word & keep) << rx_sh;
    end

endmodule

// File: rtl/sermst_shifter.sv
// Full-duplex shift engine. It keeps the word right-justified in a 32-bit
// register, taps it at bit n-1 or bit 0 by bit order, and toggles sck once
// per prescaler tick for 2n ticks. Assumes cfg is frozen while busy.
module sermst_shifter
    import sermst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             tick,
    input  cfg_t             cfg,
    input  logic [REG_W-1:0] tx_word,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic             phase,
    output logic             mosi,
    output logic [REG_W-1:0] rx_word
);

    localparam int EC_W = NB_W + 1;

    logic [REG_W-1:0] txsh_q;
    logic [REG_W-1:0] rxsh_q;
    logic [EC_W-1:0]  edge_q;
    logic             busy_q;
    logic             done_q;
    logic             phase_q;
    logic             mosi_q;
    logic [4:0]       tap;
    logic             lead;
    logic             last;
    logic             do_shift;
    logic             do_sample;
    logic             din;

    // Decode the current edge: lead edges are even counts, the last is 2n-1.
    always_comb begin
        tap       = 5'(cfg.nbits - NB_W'(1));
        lead      = ~edge_q[0];
        last      = (edge_q == EC_W'({cfg.nbits, 1'b0} - EC_W'(1)));
        do_sample = cfg.cpha ? ~lead : lead;
        do_shift  = cfg.cpha ? lead : (~lead & ~last);
        din       = cfg.loop ? mosi_q : miso;
    end

    // Transfer sequencing, data launch and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            phase_q <= 1'b0;
            mosi_q  <= 1'b0;
            edge_q  <= '0;
            txsh_q  <= '0;
            rxsh_q  <= '0;
        end else if (abort) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            phase_q <= 1'b0;
        end else if (start) begin
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
            phase_q <= 1'b0;
            edge_q  <= '0;
            rxsh_q  <= '0;
            if (!cfg.cpha) begin
                mosi_q <= cfg.msbf ? tx_word[tap] : tx_word[0];
                txsh_q <= cfg.msbf ? (tx_word << 1) : (tx_word >> 1);
            end else begin
                mosi_q <= 1'b0;
                txsh_q <= tx_word;
            end
        end else begin
            done_q <= 1'b0;
            if (busy_q && tick) begin
                phase_q <= ~phase_q;
                edge_q  <= edge_q + EC_W'(1);
                if (do_shift) begin
                    mosi_q <= cfg.msbf ? txsh_q[tap] : txsh_q[0];
                    txsh_q <= cfg.msbf ? (txsh_q << 1) : (txsh_q >> 1);
                end
                if (do_sample) begin
                    rxsh_q <= cfg.msbf ? ((rxsh_q << 1) | REG_W'(din))
                                       : ((rxsh_q >> 1) | (REG_W'(din) << tap));
                end
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign phase   = phase_q;
    assign mosi    = mosi_q;
    assign rx_word = rxsh_q;

endmodule

// File: rtl/sermst_ctrl.sv
// Register-mapped serial master: register decode, event and interrupt logic,
// and the glue around prescaler, aligner and shift engine. Assumes a
// single-cycle write strobe and a read path that has no side effects.
module sermst_ctrl
    import sermst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);

    logic [REG_W-1:0] cfg_q;
    logic [REG_W-1:0] cmd_q;
    logic [REG_W-1:0] txd_q;
    logic [REG_W-1:0] rxd_q;
    logic [1:0]       msk_q;
    logic             ev_rxw_q;
    logic             ev_txf_q;

    cfg_t             cfg;
    logic             en;
    logic             sel_cfg, sel_evt, sel_msk, sel_cmd, sel_txd, sel_rxd;
    logic             abort;
    logic             start;
    logic             eng_busy;
    logic             eng_done;
    logic             eng_phase;
    logic             tick;
    logic [REG_W-1:0] tx_word;
    logic [REG_W-1:0] rx_word;
    logic [REG_W-1:0] rx_view;

    // Address decode and control strobes.
    always_comb begin
        sel_cfg = (addr == ADDR_W'(OFS_CFG));
        sel_evt = (addr == ADDR_W'(OFS_EVT));
        sel_msk = (addr == ADDR_W'(OFS_MSK));
        sel_cmd = (addr == ADDR_W'(OFS_CMD));
        sel_txd = (addr == ADDR_W'(OFS_TXD));
        sel_rxd = (addr == ADDR_W'(OFS_RXD));
        cfg     = unpack_cfg(cfg_q);
        en      = cfg_q[B_EN];
        abort   = wr_en && sel_cfg && en && !wdata[B_EN];
        start   = wr_en && sel_txd && en && !eng_busy;
    end

    // Configuration register: fields load only while enable is clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en && sel_cfg) begin
            if (!en)
                cfg_q <= wdata & CFG_KEEP;
            else
                cfg_q[B_EN] <= wdata[B_EN];
        end
    end

    // Command and mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            msk_q <= '0;
        end else begin
            if (wr_en && sel_cmd)
                cmd_q <= wdata;
            if (wr_en && sel_msk)
                msk_q <= {wdata[E_RXW], wdata[E_TXF]};
        end
    end

    // Transmit holding copy and receive capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd_q <= '0;
            rxd_q <= '0;
        end else begin
            if (start)
                txd_q <= wdata;
            if (eng_done)
                rxd_q <= rx_view;
        end
    end

    // Event flags: write-one-to-clear, completion sets, start and abort have the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_rxw_q <= 1'b0;
            ev_txf_q <= 1'b1;
        end else begin
            if (wr_en && sel_evt) begin
                if (wdata[E_RXW]) ev_rxw_q <= 1'b0;
                if (wdata[E_TXF]) ev_txf_q <= 1'b0;
            end
            if (eng_done) begin
                ev_rxw_q <= 1'b1;
                ev_txf_q <= 1'b1;
            end
            if (start)
                ev_txf_q <= 1'b0;
            if (abort) begin
                ev_rxw_q <= 1'b0;
                ev_txf_q <= 1'b1;
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (sel_cfg) rdata = cfg_q;
        if (sel_evt) rdata = (REG_W'(ev_rxw_q) << E_RXW) | (REG_W'(ev_txf_q) << E_TXF);
        if (sel_msk) rdata = (REG_W'(msk_q[1]) << E_RXW) | (REG_W'(msk_q[0]) << E_TXF);
        if (sel_cmd) rdata = cmd_q;
        if (sel_txd) rdata = txd_q;
        if (sel_rxd) rdata = rxd_q;
    end

    // Output pins: interrupt and clock at its idle level plus engine phase.
    always_comb begin
        irq = (ev_rxw_q && msk_q[1]) || (ev_txf_q && msk_q[0]);
        sck = cfg.cpol ^ eng_phase;
    end

    sermst_prescale u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_busy),
        .slow  (cfg.slow),
        .pm    (cfg.pm),
        .tick  (tick)
    );

    sermst_align u_align (
        .cfg     (cfg),
        .tx_reg  (wdata),
        .rx_word (rx_word),
        .tx_word (tx_word),
        .rx_view (rx_view)
    );

    sermst_shifter u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .abort   (abort),
        .tick    (tick),
        .cfg     (cfg),
        .tx_word (tx_word),
        .miso    (miso),
        .busy    (eng_busy),
        .done    (eng_done),
        .phase   (eng_phase),
        .mosi    (mosi),
        .rx_word (rx_word)
    );

endmodule

// File: rtl/sermst_chk.sv
// Protocol checker for the serial master, bound to the top module.
module sermst_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       en,
    input logic       cpol,
    input logic       sck,
    input logic       ev_rxw,
    input logic       ev_txf,
    input logic       msk_rxw,
    input logic       irq
);

    // R5: clock rests at the idle level between transfers.
    p_idle_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol));

    // R7: free flag stays low for the whole transfer.
    p_free_low_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ev_txf);

    // R7: completion leaves a received word flagged unless aborted.
    p_done_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ev_rxw || !en));

    // R9: a masked-in received flag drives the interrupt.
    p_irq_rxw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rxw && msk_rxw) |-> irq);

    // R12: clearing enable stops the engine and drops the received flag.
    p_abort_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> (!busy && !ev_rxw));

    // R12: the engine never runs while disabled.
    p_busy_needs_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> en);

endmodule

bind sermst_ctrl sermst_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (eng_busy),
    .done    (eng_done),
    .en      (en),
    .cpol    (cfg.cpol),
    .sck     (sck),
    .ev_rxw  (ev_rxw_q),
    .ev_txf  (ev_txf_q),
    .msk_rxw (msk_q[1]),
    .irq     (irq)
);

// File: tb/sermst_ctrl_bench.sv
// Directed bench: one task per scenario with a behavioural serial slave.
module sermst_ctrl_bench;

    localparam int WD_CYC = 150000;

    localparam logic [31:0] M_LOOP = 32'h4000_0000;
    localparam logic [31:0] M_CPOL = 32'h2000_0000;
    localparam logic [31:0] M_CPHA = 32'h1000_0000;
    localparam logic [31:0] M_SLOW = 32'h0800_0000;
    localparam logic [31:0] M_MSBF = 32'h0400_0000;
    localparam logic [31:0] M_MSTR = 32'h0200_0000;
    localparam logic [31:0] M_EN   = 32'h0100_0000;
    localparam logic [31:0] M_ALT  = 32'h0000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, sck, mosi, miso;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // slave model state
    bit          sl_on = 0;
    logic [31:0] sl_tx = '0;
    logic [31:0] sl_rx = '0;
    int          sl_n = 8;
    bit          sl_msb = 1;
    bit          sl_cpol = 0;
    bit          sl_cpha = 0;
    int          sl_idx = 0;
    int          sl_ridx = 0;

    always #5 clk = ~clk;

    sermst_ctrl u_sermst_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
    );

    function automatic int sl_pos(int i);
        return sl_msb ? (sl_n - 1 - i) : i;
    endfunction

    assign miso = (sl_on && sl_idx >= 0 && sl_idx < sl_n) ? sl_tx[sl_pos(sl_idx)] : 1'b1;

    // Slave reacts to clock edges: present on one edge kind, capture on the other.
    always @(sck) begin
        if (sl_on) begin
            if ((sck != sl_cpol) == (sl_cpha == 1'b0)) begin
                if (sl_ridx < sl_n) sl_rx[sl_pos(sl_ridx)] = mosi;
                sl_ridx = sl_ridx + 1;
            end else begin
                sl_idx = sl_idx + 1;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_err = n_err + 1;
        $display("FAIL watchdog (R7): got hung run, expected completion");
        finish_run();
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_err = n_err + 1;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_mode(logic [31:0] m);
        wr(8'h20, m & ~M_EN);
        wr(8'h20, m);
    endtask

    task automatic arm_slave(logic [31:0] w, int n, bit msb, bit cpol, bit cpha);
        sl_tx = w; sl_rx = '0; sl_n = n; sl_msb = msb;
        sl_cpol = cpol; sl_cpha = cpha;
        sl_idx = cpha ? -1 : 0; sl_ridx = 0; sl_on = 1;
    endtask

    task automatic wait_rx();
        logic [31:0] ev;
        for (int i = 0; i < 4000; i++) begin
            rd(8'h24, ev);
            if (ev[9]) break;
        end
    endtask

    // Send one word with the slave armed, return the receive register.
    task automatic xfer(logic [31:0] tx, output logic [31:0] rx);
        wr(8'h24, 32'h0000_0200);
        wr(8'h30, tx);
        wait_rx();
        rd(8'h34, rx);
        sl_on = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h20, v); chk("R1 cfg", v, 0);
        rd(8'h24, v); chk("R1 event", v, 32'h100);
        rd(8'h28, v); chk("R1 mask", v, 0);
        rd(8'h2C, v); chk("R1 cmd", v, 0);
        rd(8'h30, v); chk("R1 txd", v, 0);
        rd(8'h34, v); chk("R1 rxd", v, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 sck", 32'(sck), 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(8'h20, 32'hFFFF_FFFF & ~M_EN);
        rd(8'h20, v); chk("R2 cfg implemented bits", v, 32'h7EFF_4000);
        wr(8'h20, 32'h0);
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, v); chk("R2 mask bits", v, 32'h300);
        wr(8'h28, 32'h0);
        wr(8'h2C, 32'hC0DE_1234);
        rd(8'h2C, v); chk("R2 command", v, 32'hC0DE_1234);
        wr(8'h30, 32'h1111_1111);
        rd(8'h30, v); chk("R7 tx ignored while disabled", v, 0);
    endtask

    task automatic t_mode0();
        logic [31:0] v;
        set_mode(M_EN | M_MSTR | M_MSBF | (32'd7 << 20));
        arm_slave(32'hA5, 8, 1, 0, 0);
        wr(8'h24, 32'h200);
        wr(8'h30, 32'h3C);
        rd(8'h24, v); chk("R7 free flag low while busy", 32'(v[8]), 0);
        wr(8'h30, 32'hFF);
        rd(8'h30, v); chk("R7 tx write while busy ignored", v, 32'h3C);
        wait_rx();
        rd(8'h34, v); chk("R5 mode0 rx word", v, 32'hA5);
        chk("R6 mode0 msb-first slave saw", sl_rx, 32'h3C);
        rd(8'h24, v); chk("R7 both flags after word", v, 32'h300);
        sl_on = 0;
    endtask

    task automatic t_mode3_lsb();
        logic [31:0] v;
        set_mode(M_EN | M_CPOL | M_CPHA | (32'd15 << 20));
        @(negedge clk); chk("R5 idle high clock", 32'(sck), 1);
        arm_slave(32'hBEEF, 16, 0, 1, 1);
        xfer(32'h1234, v);
        chk("R6 lsb-first rx word", v, 32'hBEEF);
        chk("R5 mode3 slave saw", sl_rx, 32'h1234);
    endtask

    task automatic high_time(logic [31:0] m, int exp, string tag);
        logic [31:0] v;
        int cnt = 0;
        set_mode(m | M_EN | M_LOOP | (32'd3 << 20));
        wr(8'h30, 32'h5);
        while (sck == 1'b0) @(negedge clk);
        while (sck == 1'b1) begin cnt = cnt + 1; @(negedge clk); end
        chk(tag, 32'(cnt), 32'(exp));
        wait_rx();
        rd(8'h34, v);
    endtask

    task automatic t_clock();
        high_time(32'd1 << 16, 4, "R4 fast range P=1 half period");
        high_time(M_SLOW, 32, "R4 slow range P=0 half period");
    endtask

    task automatic t_length();
        logic [31:0] v;
        set_mode(M_EN | M_LOOP | M_MSBF);
        arm_slave(32'h0, 32, 1, 0, 0);
        xfer(32'hDEAD_BEEF, v); chk("R3 32-bit word", v, 32'hDEAD_BEEF);
        set_mode(M_EN | M_LOOP | M_MSBF | (32'd3 << 20));
        xfer(32'hFFFF_FFF5, v); chk("R3 4-bit word trims", v, 32'h5);
    endtask

    task automatic t_loop();
        logic [31:0] v;
        set_mode(M_EN | M_LOOP | M_MSBF | (32'd7 << 20));
        arm_slave(32'hFF, 8, 1, 0, 0);
        xfer(32'h5A, v); chk("R11 loopback ignores miso", v, 32'h5A);
    endtask

    task automatic t_events();
        logic [31:0] v;
        wr(8'h28, 32'h200);
        @(negedge clk); chk("R9 irq on masked received", 32'(irq), 1);
        wr(8'h24, 32'h200);
        rd(8'h24, v); chk("R8 clear received only", v, 32'h100);
        chk("R9 irq drops", 32'(irq), 0);
        wr(8'h24, 32'h0);
        rd(8'h24, v); chk("R8 write zero no effect", v, 32'h100);
        wr(8'h28, 32'h100);
        @(negedge clk); chk("R9 irq on masked free", 32'(irq), 1);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R8 clear all", v, 0);
        chk("R9 irq off after clear", 32'(irq), 0);
        wr(8'h28, 32'h0);
    endtask

    task automatic t_alt();
        logic [31:0] v;
        set_mode(M_EN | M_LOOP | M_ALT | M_MSBF | (32'd7 << 20));
        xfer(32'hA700_0000, v); chk("R10 alt msb 8-bit", v, 32'h00A7_0000);
        set_mode(M_EN | M_LOOP | M_ALT | M_MSBF | (32'd11 << 20));
        xfer(32'h0ABC_0000, v); chk("R10 alt msb 12-bit", v, 32'h0ABC_0000);
        set_mode(M_EN | M_LOOP | M_ALT | (32'd7 << 20));
        xfer(32'h0000_00C3, v); chk("R10 alt lsb 8-bit", v, 32'h0000_C300);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        logic [31:0] m;
        m = M_EN | M_LOOP | M_MSBF | M_SLOW | (32'd15 << 16) | (32'd7 << 20);
        set_mode(m);
        wr(8'h30, 32'h81);
        repeat (600) @(negedge clk);
        chk("R12 clock high mid transfer", 32'(sck), 1);
        wr(8'h20, m | M_CPOL);
        rd(8'h20, v); chk("R12 field locked while enabled", v, m);
        wr(8'h20, m & ~M_EN);
        @(negedge clk); chk("R12 clock idle after abort", 32'(sck), 0);
        rd(8'h24, v); chk("R12 flags after abort", v, 32'h100);
        repeat (1200) @(negedge clk);
        rd(8'h24, v); chk("R12 no late completion", v, 32'h100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_mode0();
        t_mode3_lsb();
        t_clock();
        t_length();
        t_loop();
        t_events();
        t_alt();
        t_abort();
        finish_run();
    end

endmodule